// File: doc/BRIEF.md
# Challenge-Response Mode Change Guard

This block sits behind a serial register front end and keeps the chip's operating mode from being changed by a single stray write. Software first issues a request command. The block answers by latching a fresh pseudo-random code, which it shows on the read data path. The requested move out of Normal mode (to Init, to Flash, or to a reset request) then takes effect only if the very next command is a response. That response must name the target mode and carry the bitwise inverse of the code.

The block also guards one critical configuration byte. That byte may be written only while the mode is Init and either the external power-fail flag is high or Init was entered through a secured exchange. In every other state the byte is locked. A wrong or badly timed response sets a sticky error flag, which software reads and clears with a dedicated command.

Top module: `secure_mode_guard`

## Requirements
- R1: While reset is held and just after it, the mode is Init (code 0), the error flag is 0, the challenge and read data are 0, and the lock output equals the inverse of the power-fail input.
- R2: A request command (op 1) loads the challenge with a nonzero code that differs from the previous challenge, and the read data shows that code after the same clock edge.
- R3: A response command (op 2) that follows a request directly, is issued in Normal mode (code 1), and names target Init (0), Flash (2) or Reset (3) with data equal to the bitwise inverse of the challenge moves the mode to that target at that edge.
- R4: A response whose data is not the inverted challenge leaves the mode unchanged and sets the error flag.
- R5: Any other command between the request and the response disarms the exchange, so a later correct response is rejected and sets the error flag.
- R6: A response with no request before it, or one naming target Normal, is rejected and sets the error flag.
- R7: A configuration write (op 3) updates the configuration byte only while the mode is Init and either the power-fail input is high or Init was entered through R3. The lock output is high exactly when such writes are refused.
- R8: An error read command (op 5) places the error flag in bit 0 of the read data, with the other bits zero, and clears the flag.
- R9: A leave command (op 4) moves Init, Flash or Reset to Normal. It has no effect in Normal. Leaving Init ends the unlock earned through R3.
- R10: The challenge output holds its value on every command other than a request, so the code can be read back at any time.
- R11: After two requests in a row, only the inverse of the latest code is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | One-cycle strobe for a decoded command |
| cmdOp | input | 3 | Command: 1 request, 2 response, 3 config write, 4 leave, 5 error read; others do nothing but disarm |
| cmdTgt | input | 2 | Target mode for a response |
| cmdData | input | DATA_W | Response code or configuration byte |
| pwrFail | input | 1 | Power-fail flag from the supply monitor |
| curMode | output | 2 | Current mode: 0 Init, 1 Normal, 2 Flash, 3 Reset |
| challenge | output | DATA_W | Latest challenge code |
| rdData | output | DATA_W | Read data for request and error read commands |
| errFlag | output | 1 | Sticky rejected-response flag |
| cfgLocked | output | 1 | High when configuration writes are refused |
| cfgValue | output | DATA_W | Critical configuration byte |

## Verification
The response path is tried with four kinds of data: the inverted code, the code sent back uninverted, the inverse of a code that a newer request has replaced, and a correct inverse sent after an intervening command or without any request. These four separate the data comparison from the arming logic. Correct responses are sent to each of the three targets, and one names Normal. These confirm that the target decode is separate from the code check. Configuration writes are attempted in Normal, in Init under power-fail, in Init reached through the secured path, and in Init after a reset with power-fail low. Together these show the lock depends on mode, flag and entry path together.

// File: rtl/smg_pkg.sv
`timescale 1ns/1ps
package smg_pkg;

  typedef enum logic [1:0] {
    MODE_INIT   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_FLASH  = 2'd2,
    MODE_RESET  = 2'd3
  } mode_e;

  localparam logic [2:0] OP_REQ   = 3'd1;
  localparam logic [2:0] OP_RESP  = 3'd2;
  localparam logic [2:0] OP_CFG   = 3'd3;
  localparam logic [2:0] OP_LEAVE = 3'd4;
  localparam logic [2:0] OP_ERRRD = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic capCode;
    logic cfgWr;
    logic showErr;
  } dp_strobe_t;

endpackage

// File: rtl/smg_datapath.sv
`timescale 1ns/1ps
module smg_datapath
  import smg_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [DATA_W-1:0] TAPS    = 8'hB8,
  parameter logic [DATA_W-1:0] SEED    = 8'h01,
  parameter logic [DATA_W-1:0] CFG_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              errIn,
  output logic              codeMatch,
  output logic [DATA_W-1:0] codeQ,
  output logic [DATA_W-1:0] rdDataQ,
  output logic [DATA_W-1:0] cfgQ
);

  localparam int PAD_W = DATA_W - 1;

  logic [DATA_W-1:0] lfsrQ;
  logic [DATA_W-1:0] lfsrNext;
  logic [DATA_W-1:0] freshCode;
  logic              feedBack;

  // free-running Fibonacci LFSR, never zero
  assign feedBack = ^(lfsrQ & TAPS);
  assign lfsrNext = {lfsrQ[DATA_W-2:0], feedBack};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= SEED;
    else       lfsrQ <= lfsrNext;
  end

  // avoid handing out the same code twice in a row
  assign freshCode = (lfsrQ == codeQ) ? lfsrNext : lfsrQ;
  assign codeMatch = (cmdData == ~codeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= '0;
      rdDataQ <= '0;
    end else if (strb.capCode) begin
      codeQ   <= freshCode;
      rdDataQ <= freshCode;
    end else if (strb.showErr) begin
      rdDataQ <= {{PAD_W{1'b0}}, errIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cfgQ <= CFG_RST;
    else if (strb.cfgWr) cfgQ <= cmdData;
  end

endmodule

// File: rtl/smg_ctrl.sv
`timescale 1ns/1ps
module smg_ctrl
  import smg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] cmdTgt,
  input  logic       pwrFail,
  input  logic       codeMatch,
  output mode_e      modeQ,
  output logic       errQ,
  output logic       cfgLocked,
  output dp_strobe_t strb
);

  logic  armedQ;
  logic  secInitQ;
  logic  isReq, isResp, isCfg, isLeave, isErrRd;
  logic  respOk;
  mode_e modeNext;

  assign isReq   = cmdValid && (cmdOp == OP_REQ);
  assign isResp  = cmdValid && (cmdOp == OP_RESP);
  assign isCfg   = cmdValid && (cmdOp == OP_CFG);
  assign isLeave = cmdValid && (cmdOp == OP_LEAVE);
  assign isErrRd = cmdValid && (cmdOp == OP_ERRRD);

  assign respOk = isResp && armedQ && (modeQ == MODE_NORMAL) &&
                  (cmdTgt != MODE_NORMAL) && codeMatch;

  assign cfgLocked = !((modeQ == MODE_INIT) && (pwrFail || secInitQ));

  assign strb.capCode = isReq;
  assign strb.cfgWr   = isCfg && !cfgLocked;
  assign strb.showErr = isErrRd;

  always_comb begin
    modeNext = modeQ;
    if (respOk)
      modeNext = mode_e'(cmdTgt);
    else if (isLeave && (modeQ != MODE_NORMAL))
      modeNext = MODE_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_INIT;
      armedQ   <= 1'b0;
      errQ     <= 1'b0;
      secInitQ <= 1'b0;
    end else begin
      modeQ <= modeNext;
      if (cmdValid) armedQ <= isReq;
      if (isResp && !respOk) errQ <= 1'b1;
      else if (isErrRd)      errQ <= 1'b0;
      if (respOk && (cmdTgt == MODE_INIT))        secInitQ <= 1'b1;
      else if (isLeave && (modeQ == MODE_INIT))   secInitQ <= 1'b0;
    end
  end

endmodule

// File: rtl/secure_mode_guard.sv
`timescale 1ns/1ps
module secure_mode_guard
  import smg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] TAPS    = 8'hB8,
  parameter logic [DATA_W-1:0] SEED    = 8'h01,
  parameter logic [DATA_W-1:0] CFG_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [1:0]        cmdTgt,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              pwrFail,
  output logic [1:0]        curMode,
  output logic [DATA_W-1:0] challenge,
  output logic [DATA_W-1:0] rdData,
  output logic              errFlag,
  output logic              cfgLocked,
  output logic [DATA_W-1:0] cfgValue
);

  dp_strobe_t strb;
  mode_e      modeQ;
  logic       codeMatch;

  smg_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdTgt    (cmdTgt),
    .pwrFail   (pwrFail),
    .codeMatch (codeMatch),
    .modeQ     (modeQ),
    .errQ      (errFlag),
    .cfgLocked (cfgLocked),
    .strb      (strb)
  );

  smg_datapath #(
    .DATA_W  (DATA_W),
    .TAPS    (TAPS),
    .SEED    (SEED),
    .CFG_RST (CFG_RST)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdData   (cmdData),
    .errIn     (errFlag),
    .codeMatch (codeMatch),
    .codeQ     (challenge),
    .rdDataQ   (rdData),
    .cfgQ      (cfgValue)
  );

  assign curMode = modeQ;

endmodule

// File: rtl/secure_mode_guard_chk.sv
`timescale 1ns/1ps
module secure_mode_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [1:0]        cmdTgt,
  input logic [DATA_W-1:0] cmdData,
  input logic              pwrFail,
  input logic [1:0]        curMode,
  input logic [DATA_W-1:0] challenge,
  input logic [DATA_W-1:0] rdData,
  input logic              errFlag,
  input logic              cfgLocked,
  input logic [DATA_W-1:0] cfgValue
);

  AST_FRESH_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1) |=> (challenge != $past(challenge)) && (challenge != '0) && (rdData == challenge)); // R2

  AST_GUARDED_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curMode) == 2'd1 && curMode != 2'd1) |->
      ($past(cmdValid) && $past(cmdOp) == 3'd2 && $past(cmdData) == ~$past(challenge) && curMode == $past(cmdTgt))); // R3

  AST_BAD_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd2 && cmdData != ~challenge) |=> ($stable(curMode) && errFlag)); // R4

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cfgLocked |=> $stable(cfgValue)); // R7

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd5) |=> (!errFlag && rdData == {{(DATA_W-1){1'b0}}, $past(errFlag)})); // R8

  AST_CHAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdOp == 3'd1) |=> $stable(challenge)); // R10

  AST_LEAVE_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd4) |=> (curMode == 2'd1)); // R9

  AST_RESET_VALUES: assert property (@(posedge clk)
    !rstN |-> (curMode == 2'd0 && !errFlag && challenge == '0 && cfgLocked == !pwrFail)); // R1

endmodule

bind secure_mode_guard secure_mode_guard_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .cmdTgt    (cmdTgt),
  .cmdData   (cmdData),
  .pwrFail   (pwrFail),
  .curMode   (curMode),
  .challenge (challenge),
  .rdData    (rdData),
  .errFlag   (errFlag),
  .cfgLocked (cfgLocked),
  .cfgValue  (cfgValue)
);

// File: tb/secure_mode_guard_tb_top.sv
`timescale 1ns/1ps
module secure_mode_guard_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [1:0] cmdTgt = '0;
  logic [7:0] cmdData = '0;
  logic       pwrFail = 1'b1;
  logic [1:0] curMode;
  logic [7:0] challenge;
  logic [7:0] rdData;
  logic       errFlag;
  logic       cfgLocked;
  logic [7:0] cfgValue;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  secure_mode_guard dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdTgt(cmdTgt), .cmdData(cmdData), .pwrFail(pwrFail),
    .curMode(curMode), .challenge(challenge), .rdData(rdData),
    .errFlag(errFlag), .cfgLocked(cfgLocked), .cfgValue(cfgValue)
  );

  // dsel: 0 inverted challenge, 1 plain challenge, 2 literal
  typedef struct packed {
    logic [2:0] op;
    logic [1:0] tgt;
    logic [1:0] dsel;
    logic [7:0] lit;
    logic       pwr;
    logic [1:0] expMode;
    logic       expErr;
    logic       expLocked;
    logic [7:0] expCfg;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 2'd0, 2'd2, 8'h5A, 1'b1, 2'd0, 1'b0, 1'b0, 8'h5A, 4'd7},  // R7 unlocked by power-fail
    '{3'd4, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd9},  // R9 Init to Normal
    '{3'd3, 2'd0, 2'd2, 8'h33, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd7},  // R7 locked in Normal
    '{3'd1, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd2},  // R2
    '{3'd2, 2'd2, 2'd0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b1, 8'h5A, 4'd3},  // R3 to Flash
    '{3'd4, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd9},  // R9 Flash to Normal
    '{3'd1, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd2},  // R2
    '{3'd2, 2'd3, 2'd1, 8'h00, 1'b1, 2'd1, 1'b1, 1'b1, 8'h5A, 4'd4},  // R4 uninverted
    '{3'd5, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd8},  // R8
    '{3'd1, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd2},  // R2
    '{3'd3, 2'd0, 2'd2, 8'h77, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd5},  // R5 intervening command
    '{3'd2, 2'd0, 2'd0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b1, 8'h5A, 4'd5},  // R5 rejected
    '{3'd5, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd8},  // R8
    '{3'd2, 2'd0, 2'd0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b1, 8'h5A, 4'd6},  // R6 no request
    '{3'd5, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd8},  // R8
    '{3'd1, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd2},  // R2
    '{3'd2, 2'd1, 2'd0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b1, 8'h5A, 4'd6},  // R6 target Normal
    '{3'd5, 2'd0, 2'd2, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd8},  // R8
    '{3'd1, 2'd0, 2'd2, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'h5A, 4'd2},  // R2
    '{3'd2, 2'd0, 2'd0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'h5A, 4'd3},  // R3 to Init, unlocks
    '{3'd3, 2'd0, 2'd2, 8'hC3, 1'b0, 2'd0, 1'b0, 1'b0, 8'hC3, 4'd7},  // R7 secured write
    '{3'd4, 2'd0, 2'd2, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'hC3, 4'd9},  // R9 ends unlock
    '{3'd1, 2'd0, 2'd2, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'hC3, 4'd2},  // R2
    '{3'd2, 2'd3, 2'd0, 8'h00, 1'b0, 2'd3, 1'b0, 1'b1, 8'hC3, 4'd3},  // R3 to Reset
    '{3'd4, 2'd0, 2'd2, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'hC3, 4'd9},  // R9 Reset to Normal
    '{3'd4, 2'd0, 2'd2, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'hC3, 4'd9},  // R9 no effect in Normal
    '{3'd0, 2'd0, 2'd2, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'hC3, 4'd10}  // R10 unused op
  };

  task automatic check(input logic ok, input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [1:0] tgt, input logic [7:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdTgt = tgt; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] c1, c2;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(curMode == 2'd0, 1, "reset mode", {6'd0, curMode}, 8'd0);
    check(!errFlag && challenge == 8'd0 && rdData == 8'd0, 1, "reset err/chal/rd", challenge, 8'd0);
    check(cfgLocked == 1'b0, 1, "reset lock with power-fail", {7'd0, cfgLocked}, 8'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] prevChal, data;
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      pwrFail  = v.pwr;
      prevChal = challenge;
      case (v.dsel)
        2'd0:    data = ~challenge;
        2'd1:    data = challenge;
        default: data = v.lit;
      endcase
      doCmd(v.op, v.tgt, data);
      check(curMode == v.expMode, int'(v.req), $sformatf("vec %0d mode", i), {6'd0, curMode}, {6'd0, v.expMode});
      check(errFlag == v.expErr, int'(v.req), $sformatf("vec %0d err", i), {7'd0, errFlag}, {7'd0, v.expErr});
      check(cfgLocked == v.expLocked, int'(v.req), $sformatf("vec %0d lock", i), {7'd0, cfgLocked}, {7'd0, v.expLocked});
      check(cfgValue == v.expCfg, int'(v.req), $sformatf("vec %0d cfg", i), cfgValue, v.expCfg);
      if (v.op == 3'd1) begin
        // R2 fresh, nonzero, echoed on read data
        check(challenge != prevChal && challenge != 8'd0 && rdData == challenge, 2,
              $sformatf("vec %0d new code", i), challenge, prevChal);
      end else begin
        // R10 challenge holds
        check(challenge == prevChal, 10, $sformatf("vec %0d chal hold", i), challenge, prevChal);
      end
      if (v.op == 3'd5)  // R8 read data bit 0 shows flag before clear
        check(rdData == {7'd0, VECS[i-1].expErr}, 8, $sformatf("vec %0d err read", i), rdData, {7'd0, VECS[i-1].expErr});
    end

    // R11 two requests: older code is rejected
    doCmd(3'd1, 2'd0, 8'd0); c1 = challenge;
    doCmd(3'd1, 2'd0, 8'd0); c2 = challenge;
    check(c1 != c2, 11, "second code differs", c2, c1);
    doCmd(3'd2, 2'd2, ~c1);
    check(curMode == 2'd1 && errFlag, 11, "stale code rejected", {6'd0, curMode}, 8'd1);
    doCmd(3'd5, 2'd0, 8'd0);
    doCmd(3'd1, 2'd0, 8'd0);
    doCmd(3'd1, 2'd0, 8'd0);
    doCmd(3'd2, 2'd2, ~challenge);
    check(curMode == 2'd2 && !errFlag, 11, "latest code accepted", {6'd0, curMode}, 8'd2);

    // R1/R7 reset with power-fail low: Init but locked
    @(negedge clk);
    pwrFail = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(cfgLocked == 1'b1 && curMode == 2'd0, 1, "reset lock no power-fail", {7'd0, cfgLocked}, 8'd1);
    rstN = 1'b1;
    doCmd(3'd3, 2'd0, 8'hE1);
    check(cfgValue == 8'h00, 7, "write refused in plain Init", cfgValue, 8'h00);
    pwrFail = 1'b1;
    @(negedge clk);
    check(cfgLocked == 1'b0, 7, "unlock follows power-fail", {7'd0, cfgLocked}, 8'd0);
    doCmd(3'd3, 2'd0, 8'hE1);
    check(cfgValue == 8'hE1, 7, "write taken with power-fail", cfgValue, 8'hE1);
    // R6 response outside Normal
    doCmd(3'd1, 2'd0, 8'd0);
    doCmd(3'd2, 2'd2, ~challenge);
    check(curMode == 2'd0 && errFlag, 6, "response outside Normal", {6'd0, curMode}, 8'd0);

    finishRun();
  end

endmodule